// File: doc/BRIEF.md
# Partial Register Stall Detector

This block sits beside the rename stage of an out-of-order core whose 32-bit architectural registers can also be written and read as a low byte (bits 7:0), a high byte (bits 15:8) or a low half (bits 15:0). For each register it keeps the youngest write that touched only part of that register and has not yet retired. For every instruction presented at decode, it decides whether the source read has to wait for that write to retire. When it must wait, the block raises a stall and reports the tag it is waiting on. The instruction stays at decode until the stall drops.

The hazard depends on the sub-field overlap and on the instruction class, not on the register number alone. A read that needs bits the pending write produced, together with bits it did not produce, has to wait. A sign- or zero-extending move, or a copy into a segment register, also waits when it reads a sub-register that a plain move wrote. A zeroing idiom on the full register before the partial write lets a later wide read go ahead without waiting. A flush cancels that suppression. A partial write is treated as retired once more than a set number of later instructions have been accepted. Two counters record how many instructions stalled and for how many cycles.

Top module: `pstall_detector`

## Requirements
- R1: A read whose sub-field mask overlaps the lanes of a pending partial write on the same register, and also covers at least one lane that write did not produce, raises `stall` while `dec_valid` is high. `wait_tag` then equals the tag of the youngest pending partial write to that register. Lanes: width code 0 = bits 7:0, 1 = bits 15:8, 2 = bits 15:0, 3 = bits 31:0.
- R2: A read whose lanes lie wholly inside the pending write's lanes, or do not overlap them at all, does not stall by this rule.
- R3: A retire of the pending tag (`ret_valid` with a matching `ret_tag`) removes the record at the clock edge, and the held read no longer stalls in the next cycle.
- R4: Class code 1 (plain move) writing a partial register, followed by class 3 (extending move) or class 4 (segment copy) reading overlapping lanes of that register, stalls. A partial write of class 0 (ALU) followed by the same read does not stall.
- R5: A full-width write of class 2 (zeroing idiom) marks the register's upper bits as known zero. A later partial write then causes no R1 stall. A full-width write of any other class clears that mark.
- R6: `flush_mispredict` or `flush_irq` forces `stall` low in the same cycle. It also drops every pending record and every known-zero mark, so a zeroing idiom followed by a flush no longer suppresses the stall.
- R7: A partial write with more than AGE_LIMIT (default 40) accepted instructions after it no longer causes a stall. With exactly AGE_LIMIT instructions after it, the read still stalls.
- R8: `stall_events` increases by one for each instruction that begins stalling. `stall_cycles` increases by one for every cycle in which `stall` is high.
- R9: An accepted full 32-bit write to a register drops that register's pending partial record.
- R10: After reset, `stall` is low, `wait_tag` is zero and both counters are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_valid | input | 1 | An instruction is presented at decode |
| dec_tag | input | TAGW | Tag of the presented instruction |
| dec_dst_en | input | 1 | Instruction writes a register |
| dec_dst | input | RIDXW | Destination register index |
| dec_dst_w | input | 2 | Destination width code |
| dec_src_en | input | 1 | Instruction reads a register |
| dec_src | input | RIDXW | Source register index |
| dec_src_w | input | 2 | Source width code |
| dec_cls | input | 3 | Instruction class code |
| ret_valid | input | 1 | A tag retires this cycle |
| ret_tag | input | TAGW | Retiring tag |
| flush_mispredict | input | 1 | Branch mispredict flush |
| flush_irq | input | 1 | Interrupt flush |
| stall | output | 1 | Presented instruction must wait |
| wait_tag | output | TAGW | Tag being waited on, zero when not stalled |
| stall_events | output | CNTW | Count of stalled instructions |
| stall_cycles | output | CNTW | Count of stalled cycles |

## Verification
The bench covers lane pairings that share a register but must not stall: a high byte read after a low byte write, and a byte read inside a pending half write. A design that compared register numbers alone would stall on these. It runs the age window at exactly AGE_LIMIT and at AGE_LIMIT+1 instructions, which exposes an off-by-one error in the expiry counter. It checks that a zeroing idiom suppresses the stall only when it used the zeroing class and no flush came between it and the partial write. A design that kept the mark across a flush, or set it on any full write, would let a hazard through. It holds a stalled read over a retire and over a flush, which shows whether the release is late or whether the counters count cycles as events.

// File: rtl/pstall_pkg.sv
package pstall_pkg;

  typedef enum logic [1:0] {
    W_LO8 = 2'd0,
    W_HI8 = 2'd1,
    W_16  = 2'd2,
    W_32  = 2'd3
  } width_e;

  typedef enum logic [2:0] {
    C_ALU  = 3'd0,
    C_MOV  = 3'd1,
    C_ZERO = 3'd2,
    C_EXT  = 3'd3,
    C_SEG  = 3'd4
  } cls_e;

  localparam int LANES = 3;
  typedef logic [LANES-1:0] lane_t;

  // lane 0 = bits 7:0, lane 1 = bits 15:8, lane 2 = bits 31:16
  function automatic lane_t lanes_of(input width_e w);
    case (w)
      W_LO8:   return 3'b001;
      W_HI8:   return 3'b010;
      W_16:    return 3'b011;
      default: return 3'b111;
    endcase
  endfunction

  function automatic logic lanes_overlap(input lane_t a, input lane_t b);
    return (a & b) != '0;
  endfunction

  // read needs produced lanes plus lanes the pending write did not produce
  function automatic logic widen_hit(input lane_t rd, input lane_t wr);
    return lanes_overlap(rd, wr) && ((rd & ~wr) != '0);
  endfunction

endpackage

// File: rtl/pstall_track.sv
module pstall_track
  import pstall_pkg::*;
#(
  parameter int TAGW      = 6,
  parameter int AGE_LIMIT = 40
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            flush,
  input  logic            tick,
  input  logic            wr_en,
  input  lane_t           wr_lanes,
  input  logic            wr_full,
  input  logic            wr_zero,
  input  logic            wr_mov,
  input  logic [TAGW-1:0] wr_tag,
  input  logic            ret_valid,
  input  logic [TAGW-1:0] ret_tag,
  output logic            rec_valid,
  output logic [TAGW-1:0] rec_tag,
  output lane_t           rec_lanes,
  output logic            rec_kz,
  output logic            rec_mov
);
  localparam int AGEW = $clog2(AGE_LIMIT + 1) + 1;

  logic            kz_flag;
  logic [AGEW-1:0] age;
  logic            retire_hit;
  logic            age_out;

  assign retire_hit = ret_valid && (ret_tag == rec_tag);
  assign age_out    = tick && (age == AGEW'(AGE_LIMIT));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rec_valid <= 1'b0;
      rec_tag   <= '0;
      rec_lanes <= '0;
      rec_kz    <= 1'b0;
      rec_mov   <= 1'b0;
      kz_flag   <= 1'b0;
      age       <= '0;
    end else if (flush) begin
      rec_valid <= 1'b0;
      rec_lanes <= '0;
      rec_mov   <= 1'b0;
      kz_flag   <= 1'b0;
      age       <= '0;
    end else if (wr_en) begin
      if (wr_full) begin
        rec_valid <= 1'b0;
        rec_lanes <= '0;
        rec_mov   <= 1'b0;
        kz_flag   <= wr_zero;
        age       <= '0;
      end else begin
        rec_valid <= 1'b1;
        rec_tag   <= wr_tag;
        rec_lanes <= (rec_valid ? rec_lanes : '0) | wr_lanes;
        rec_mov   <= (rec_valid && rec_mov) || wr_mov;
        rec_kz    <= kz_flag;
        age       <= '0;
      end
    end else if (rec_valid && (retire_hit || age_out)) begin
      rec_valid <= 1'b0;
      rec_lanes <= '0;
      rec_mov   <= 1'b0;
      age       <= '0;
    end else if (rec_valid && tick) begin
      age <= age + 1'b1;
    end
  end

endmodule

// File: rtl/pstall_hazard.sv
module pstall_hazard
  import pstall_pkg::*;
#(
  parameter int TAGW = 6
) (
  input  logic            dec_valid,
  input  logic            flush,
  input  logic            src_en,
  input  lane_t           src_lanes,
  input  cls_e            cls,
  input  logic            rec_valid,
  input  logic [TAGW-1:0] rec_tag,
  input  lane_t           rec_lanes,
  input  logic            rec_kz,
  input  logic            rec_mov,
  output logic            wide_hit,
  output logic            ext_hit,
  output logic            stall,
  output logic [TAGW-1:0] wait_tag
);
  logic live;

  assign live     = rec_valid && src_en;
  assign wide_hit = live && widen_hit(src_lanes, rec_lanes) && !rec_kz;
  assign ext_hit  = live && rec_mov && ((cls == C_EXT) || (cls == C_SEG))
                    && lanes_overlap(src_lanes, rec_lanes);
  assign stall    = dec_valid && !flush && (wide_hit || ext_hit);
  assign wait_tag = stall ? rec_tag : '0;

endmodule

// File: rtl/pstall_count.sv
module pstall_count #(
  parameter int CNTW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            stall,
  output logic            stall_start,
  output logic [CNTW-1:0] stall_events,
  output logic [CNTW-1:0] stall_cycles
);
  logic stall_q;

  assign stall_start = stall && !stall_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stall_q      <= 1'b0;
      stall_events <= '0;
      stall_cycles <= '0;
    end else begin
      stall_q <= stall;
      if (stall_start) stall_events <= stall_events + 1'b1;
      if (stall)       stall_cycles <= stall_cycles + 1'b1;
    end
  end

endmodule

// File: rtl/pstall_detector.sv
module pstall_detector
  import pstall_pkg::*;
#(
  parameter int NREG      = 8,
  parameter int TAGW      = 6,
  parameter int CNTW      = 32,
  parameter int AGE_LIMIT = 40,
  localparam int RIDXW    = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dec_valid,
  input  logic [TAGW-1:0]  dec_tag,
  input  logic             dec_dst_en,
  input  logic [RIDXW-1:0] dec_dst,
  input  logic [1:0]       dec_dst_w,
  input  logic             dec_src_en,
  input  logic [RIDXW-1:0] dec_src,
  input  logic [1:0]       dec_src_w,
  input  logic [2:0]       dec_cls,
  input  logic             ret_valid,
  input  logic [TAGW-1:0]  ret_tag,
  input  logic             flush_mispredict,
  input  logic             flush_irq,
  output logic             stall,
  output logic [TAGW-1:0]  wait_tag,
  output logic [CNTW-1:0]  stall_events,
  output logic [CNTW-1:0]  stall_cycles
);
  logic            flush;
  logic            accept;
  logic            stall_start;
  logic            hz_wide;
  logic            hz_ext;
  cls_e            cls;
  lane_t           dst_lanes;
  lane_t           src_lanes;

  logic            rv   [NREG];
  logic [TAGW-1:0] rtag [NREG];
  lane_t           rlan [NREG];
  logic            rkz  [NREG];
  logic            rmov [NREG];

  assign flush     = flush_mispredict || flush_irq;
  assign accept    = dec_valid && !stall && !flush;
  assign cls       = cls_e'(dec_cls);
  assign dst_lanes = lanes_of(width_e'(dec_dst_w));
  assign src_lanes = lanes_of(width_e'(dec_src_w));

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic wr_here;
    assign wr_here = accept && dec_dst_en && (dec_dst == RIDXW'(g));
    pstall_track #(.TAGW(TAGW), .AGE_LIMIT(AGE_LIMIT)) u_track (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (flush),
      .tick      (accept),
      .wr_en     (wr_here),
      .wr_lanes  (dst_lanes),
      .wr_full   (width_e'(dec_dst_w) == W_32),
      .wr_zero   (cls == C_ZERO),
      .wr_mov    (cls == C_MOV),
      .wr_tag    (dec_tag),
      .ret_valid (ret_valid),
      .ret_tag   (ret_tag),
      .rec_valid (rv[g]),
      .rec_tag   (rtag[g]),
      .rec_lanes (rlan[g]),
      .rec_kz    (rkz[g]),
      .rec_mov   (rmov[g])
    );
  end

  pstall_hazard #(.TAGW(TAGW)) u_hazard (
    .dec_valid (dec_valid),
    .flush     (flush),
    .src_en    (dec_src_en),
    .src_lanes (src_lanes),
    .cls       (cls),
    .rec_valid (rv[dec_src]),
    .rec_tag   (rtag[dec_src]),
    .rec_lanes (rlan[dec_src]),
    .rec_kz    (rkz[dec_src]),
    .rec_mov   (rmov[dec_src]),
    .wide_hit  (hz_wide),
    .ext_hit   (hz_ext),
    .stall     (stall),
    .wait_tag  (wait_tag)
  );

  pstall_count #(.CNTW(CNTW)) u_count (
    .clk          (clk),
    .rst_n        (rst_n),
    .stall        (stall),
    .stall_start  (stall_start),
    .stall_events (stall_events),
    .stall_cycles (stall_cycles)
  );

endmodule

// File: rtl/pstall_checker.sv
module pstall_checker #(
  parameter int TAGW = 6,
  parameter int CNTW = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            dec_valid,
  input logic            flush,
  input logic            accept,
  input logic            hz_wide,
  input logic            hz_ext,
  input logic            ret_valid,
  input logic [TAGW-1:0] ret_tag,
  input logic            stall,
  input logic [TAGW-1:0] wait_tag,
  input logic [CNTW-1:0] stall_events,
  input logic [CNTW-1:0] stall_cycles
);

  p_stall_cause_r1: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (dec_valid && (hz_wide || hz_ext) && !accept));

  p_retire_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && ret_valid && ret_tag == wait_tag) |=> !stall);

  p_flush_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !stall);

  p_cycle_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> (stall_cycles == $past(stall_cycles) + 1'b1));

  p_event_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stall) |=> (stall_events == $past(stall_events) + 1'b1));

  p_event_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !stall |=> $stable(stall_events));

endmodule

bind pstall_detector pstall_checker #(.TAGW(TAGW), .CNTW(CNTW)) u_pstall_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .dec_valid    (dec_valid),
  .flush        (flush),
  .accept       (accept),
  .hz_wide      (hz_wide),
  .hz_ext       (hz_ext),
  .ret_valid    (ret_valid),
  .ret_tag      (ret_tag),
  .stall        (stall),
  .wait_tag     (wait_tag),
  .stall_events (stall_events),
  .stall_cycles (stall_cycles)
);

// File: tb/pstall_detector_bench.sv
module pstall_detector_bench;
  localparam int TAGW = 6;
  localparam int CNTW = 32;
  localparam int AGEL = 40;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            dec_valid = 1'b0;
  logic [TAGW-1:0] dec_tag = '0;
  logic            dec_dst_en = 1'b0;
  logic [2:0]      dec_dst = '0;
  logic [1:0]      dec_dst_w = '0;
  logic            dec_src_en = 1'b0;
  logic [2:0]      dec_src = '0;
  logic [1:0]      dec_src_w = '0;
  logic [2:0]      dec_cls = '0;
  logic            ret_valid = 1'b0;
  logic [TAGW-1:0] ret_tag = '0;
  logic            flush_mispredict = 1'b0;
  logic            flush_irq = 1'b0;
  logic            stall;
  logic [TAGW-1:0] wait_tag;
  logic [CNTW-1:0] stall_events;
  logic [CNTW-1:0] stall_cycles;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  pstall_detector u_pstall_detector (
    .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_tag(dec_tag),
    .dec_dst_en(dec_dst_en), .dec_dst(dec_dst), .dec_dst_w(dec_dst_w),
    .dec_src_en(dec_src_en), .dec_src(dec_src), .dec_src_w(dec_src_w),
    .dec_cls(dec_cls), .ret_valid(ret_valid), .ret_tag(ret_tag),
    .flush_mispredict(flush_mispredict), .flush_irq(flush_irq),
    .stall(stall), .wait_tag(wait_tag),
    .stall_events(stall_events), .stall_cycles(stall_cycles)
  );

  // width codes: 0 low byte, 1 high byte, 2 low half, 3 full
  // class codes: 0 alu, 1 move, 2 zeroing, 3 extend, 4 segment copy

  task automatic check(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic present(input int tag, input bit de, input int d, input int dw,
                         input bit se, input int s, input int sw, input int c);
    @(negedge clk);
    dec_valid = 1'b1; dec_tag = TAGW'(tag);
    dec_dst_en = de; dec_dst = 3'(d); dec_dst_w = 2'(dw);
    dec_src_en = se; dec_src = 3'(s); dec_src_w = 2'(sw);
    dec_cls = 3'(c);
    #2;
  endtask

  task automatic wr(input int tag, input int d, input int dw, input int c);
    present(tag, 1'b1, d, dw, 1'b0, 0, 0, c);
  endtask

  task automatic rd(input int tag, input int s, input int sw, input int c);
    present(tag, 1'b0, 0, 0, 1'b1, s, sw, c);
  endtask

  task automatic quiet();
    @(negedge clk);
    dec_valid = 1'b0; dec_dst_en = 1'b0; dec_src_en = 1'b0;
    #2;
  endtask

  task automatic flush_all();
    @(negedge clk);
    dec_valid = 1'b0; flush_mispredict = 1'b1;
    @(negedge clk);
    flush_mispredict = 1'b0;
  endtask

  task automatic t_reset();
    check("R10", "stall after reset", stall, 0);
    check("R10", "wait_tag after reset", wait_tag, 0);
    check("R10", "events after reset", stall_events, 0);
    check("R10", "cycles after reset", stall_cycles, 0);
  endtask

  task automatic t_widen();
    flush_all();
    wr(1, 0, 0, 1);           // low byte of reg0
    rd(2, 0, 3, 0);           // full read
    check("R1", "full after low byte stall", stall, 1);
    check("R1", "wait_tag", wait_tag, 1);
    rd(3, 0, 2, 0);           // half read after low byte
    check("R1", "half after low byte stall", stall, 1);
    wr(4, 1, 1, 0);           // high byte of reg1
    rd(5, 1, 2, 0);
    check("R1", "half after high byte stall", stall, 1);
    check("R1", "wait_tag high byte", wait_tag, 4);
    quiet();
  endtask

  task automatic t_noalias();
    flush_all();
    wr(6, 0, 0, 1);
    rd(7, 0, 1, 0);           // high byte vs low byte write: disjoint
    check("R2", "disjoint byte read", stall, 0);
    rd(8, 0, 0, 0);           // same low byte
    check("R2", "contained byte read", stall, 0);
    wr(9, 2, 2, 0);           // half write reg2
    rd(10, 2, 0, 0);
    check("R2", "byte inside half write", stall, 0);
    rd(11, 2, 3, 0);
    check("R1", "full after half write", stall, 1);
    check("R1", "wait_tag half write", wait_tag, 9);
    quiet();
  endtask

  task automatic t_retire();
    flush_all();
    wr(12, 3, 0, 1);
    rd(13, 3, 3, 0);
    check("R3", "stall before retire", stall, 1);
    @(negedge clk);
    ret_valid = 1'b1; ret_tag = TAGW'(12);
    #2;
    check("R3", "stall during retire cycle", stall, 1);
    @(negedge clk);
    ret_valid = 1'b0;
    #2;
    check("R3", "stall after retire", stall, 0);
    quiet();
  endtask

  task automatic t_class();
    flush_all();
    wr(14, 5, 0, 1);          // move writes low byte
    rd(15, 5, 0, 3);          // extend reads low byte
    check("R4", "extend after move", stall, 1);
    check("R4", "wait_tag extend", wait_tag, 14);
    wr(16, 6, 2, 1);          // move writes half
    rd(17, 6, 2, 4);          // segment copy of half
    check("R4", "segment copy after move", stall, 1);
    wr(18, 7, 0, 0);          // alu writes low byte
    rd(19, 7, 0, 3);
    check("R4", "extend after alu write", stall, 0);
    quiet();
  endtask

  task automatic t_zero();
    flush_all();
    wr(20, 2, 3, 2);          // zeroing idiom
    wr(21, 2, 0, 1);
    rd(22, 2, 3, 0);
    check("R5", "wide read after zeroing", stall, 0);
    wr(23, 3, 3, 0);          // other full write
    wr(24, 3, 0, 1);
    rd(25, 3, 3, 0);
    check("R5", "wide read after non-idiom clear", stall, 1);
    check("R5", "wait_tag non-idiom", wait_tag, 24);
    quiet();
  endtask

  task automatic t_flush();
    flush_all();
    wr(26, 4, 3, 2);          // zeroing idiom
    flush_all();              // cancels it
    wr(27, 4, 0, 1);
    rd(28, 4, 3, 0);
    check("R6", "zeroing cancelled by flush", stall, 1);
    @(negedge clk);
    flush_irq = 1'b1;
    #2;
    check("R6", "stall in flush cycle", stall, 0);
    @(negedge clk);
    flush_irq = 1'b0;
    #2;
    check("R6", "stall after flush", stall, 0);
    quiet();
  endtask

  task automatic t_full();
    flush_all();
    wr(29, 0, 0, 1);
    wr(30, 0, 3, 0);
    rd(31, 0, 3, 0);
    check("R9", "full write drops record", stall, 0);
    quiet();
  endtask

  task automatic t_age(input int gap, input int exp);
    flush_all();
    wr(32, 1, 0, 1);
    for (int i = 0; i < gap; i++) present(40, 1'b0, 0, 0, 1'b0, 0, 0, 0);
    rd(33, 1, 3, 0);
    check("R7", $sformatf("read after %0d fillers", gap), stall, exp);
    quiet();
  endtask

  task automatic t_count();
    longint ev0, cy0;
    flush_all();
    wr(34, 6, 1, 1);
    quiet();
    ev0 = stall_events; cy0 = stall_cycles;
    rd(35, 6, 3, 0);
    @(negedge clk);
    @(negedge clk);
    ret_valid = 1'b1; ret_tag = TAGW'(34);
    @(negedge clk);
    ret_valid = 1'b0; dec_valid = 1'b0;
    #2;
    check("R8", "stall events delta", stall_events - ev0, 1);
    check("R8", "stall cycles delta", stall_cycles - cy0, 3);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #2;
    t_reset();
    t_widen();
    t_noalias();
    t_retire();
    t_class();
    t_zero();
    t_flush();
    t_full();
    t_age(AGEL, 1);
    t_age(AGEL + 1, 0);
    t_count();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule